// File: doc/BRIEF.md
# Single-Word Register Read Bridge over a Synchronous Slave FIFO

This block sits on the FPGA side of a 32-bit synchronous slave-FIFO link to a USB bridge device, and it is the bus master: it drives every control strobe. The host uses the link as a register read channel. It places one 32-bit address word in the inbound channel. The block answers with one 32-bit data word on the outbound channel.

The block watches the inbound ready flag. When the flag shows buffered data, the block enables the bridge's output and issues exactly one read strobe. It then captures the address word after the bridge's fixed read latency. It decodes that address against a small constant register file. Next it waits until the outbound ready flag shows buffer space. It writes the data word with a single write strobe and then pulses packet-end, so the bridge commits the short buffer to the host at once. The active level of each ready flag is set by its own parameter. Any depth or threshold on this link is counted in bus-width words.

Top module: `sfifo_reg_bridge`

## Requirements
- R1: While `rst` is high, and on the clock after it, `oe_n`, `rd_n`, `wr_n` and `pkt_end_n` are all 1 and `dq_oe` is 0.
- R2: The inbound flag shows data when it is at the level chosen by `IN_RDY_LOW` (default 1: a low flag means data present). `oe_n` falls only on the clock after such a sample. It stays high for as long as the flag shows no data.
- R3: `oe_n` is low for four consecutive clocks per transaction. `rd_n` is low only in the second of these, so output enable leads the read strobe by one clock.
- R4: Each transaction issues exactly one `rd_n` low pulse of one clock, which reads one bus word.
- R5: The address is the value on `dq_in` in the clock two cycles after the one in which `rd_n` was low (the capture edge is the second edge after the strobe edge).
- R6: An address with bits [31:6] all zero selects word `addr[5:2]`, and bits [1:0] are ignored. Word i holds `32'h1234_0000 ^ (i * 32'h0101_0101)`, truncated to 32 bits.
- R7: Any address with a nonzero bit in [31:6] returns `32'hDEADBEEF`.
- R8: The outbound flag shows space when it is at the level chosen by `OUT_RDY_LOW` (default 0: a high flag means space). `wr_n` goes low only on the clock after a sample showing space. The block waits as long as no space is shown.
- R9: `wr_n` is low for exactly one clock per transaction. `dq_oe` is 1 in exactly that clock, with the data word on `dq_out`. At most one of `rd_n`, `wr_n` and `pkt_end_n` is low at any time.
- R10: `pkt_end_n` is low for exactly the one clock after the write. The block then returns to idle, and each address read yields exactly one committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| in_flag | input | 1 | Inbound channel ready flag, polarity per `IN_RDY_LOW` |
| out_flag | input | 1 | Outbound channel ready flag, polarity per `OUT_RDY_LOW` |
| dq_in | input | 32 | Data bus value as received from the bridge |
| dq_out | output | 32 | Data word to drive onto the bus |
| dq_oe | output | 1 | Bus drive enable; the bus is released when 0 |
| oe_n | output | 1 | Bridge output enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| pkt_end_n | output | 1 | Packet-end commit strobe, active low |

## Verification
The assertions assume a bridge that holds each flag steady between clock edges. They also assume the inbound flag shows data only when an address is really buffered, and that the address word appears on the bus exactly two clocks after the read strobe. The bench's bridge model keeps to this: it drives flags and data only at the falling edge, and it raises the inbound flag only while its host queue holds a word. On every other cycle it places an obviously wrong value on `dq_in`, so a capture made at the wrong time corrupts the returned word. The outbound flag is held inactive for long stretches to exercise the wait for space.

// File: rtl/sfrb_pkg.sv
package sfrb_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_IN,
        ST_READ,
        ST_LOOKUP,
        ST_WAIT_OUT,
        ST_WRITE,
        ST_COMMIT
    } sfrb_state_e;

    typedef struct packed {
        logic rd_n;
        logic oe_n;
        logic wr_n;
        logic pkt_n;
        logic drive;
    } sfrb_strobes_t;

    localparam sfrb_strobes_t STROBES_IDLE = '{rd_n: 1'b1, oe_n: 1'b1, wr_n: 1'b1, pkt_n: 1'b1, drive: 1'b0};

    // Constant content of register word idx.
    function automatic logic [BUS_W-1:0] reg_word(input int idx, input logic [BUS_W-1:0] seed);
        logic [BUS_W-1:0] step;
        step = BUS_W'(idx) * 32'h0101_0101;
        return seed ^ step;
    endfunction

endpackage

// File: rtl/sfrb_flag_norm.sv
module sfrb_flag_norm #(
    parameter bit ACT_LOW = 1'b0
) (
    input  logic flag_raw,
    output logic ready
);
    generate
        if (ACT_LOW) begin : g_low
            assign ready = ~flag_raw;
        end else begin : g_high
            assign ready = flag_raw;
        end
    endgenerate
endmodule

// File: rtl/sfrb_regfile.sv
module sfrb_regfile
    import sfrb_pkg::*;
#(
    parameter int              DW    = BUS_W,
    parameter int              DEPTH = 16,
    parameter logic [DW-1:0]   SEED  = 32'h1234_0000,
    parameter logic [DW-1:0]   MISS  = 32'hDEAD_BEEF
) (
    input  logic [DW-1:0] addr,
    output logic [DW-1:0] rdata
);
    localparam int IDXW = $clog2(DEPTH);
    localparam int LO   = $clog2(DW / 8);

    logic [DW-1:0] rom [DEPTH];
    logic [DW-1:0] widx;
    logic          hit;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_rom
            assign rom[g] = DW'(reg_word(g, BUS_W'(SEED)));
        end
    endgenerate

    always_comb begin
        widx  = addr >> LO;
        hit   = (widx >> IDXW) == '0;
        rdata = hit ? rom[widx[IDXW-1:0]] : MISS;
    end
endmodule

// File: rtl/sfrb_ctrl.sv
module sfrb_ctrl
    import sfrb_pkg::*;
#(
    parameter int DW     = BUS_W,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_ready,
    input  logic          out_ready,
    input  logic [DW-1:0] dq_in,
    input  logic [DW-1:0] lookup_data,
    output logic [DW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output sfrb_strobes_t strb
);
    // phase 0: enable only, phase 1: read strobe, last phase: capture
    localparam int PH_LAST = RD_LAT + 1;
    localparam int PHW     = $clog2(PH_LAST + 1);

    sfrb_state_e    state;
    logic [PHW-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ph     <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE:     state <= ST_WAIT_IN;
                ST_WAIT_IN:  if (in_ready) begin
                                 state <= ST_READ;
                                 ph    <= '0;
                             end
                ST_READ:     if (ph == PHW'(PH_LAST)) begin
                                 addr_q <= dq_in;
                                 ph     <= '0;
                                 state  <= ST_LOOKUP;
                             end else begin
                                 ph <= ph + 1'b1;
                             end
                ST_LOOKUP:   begin
                                 data_q <= lookup_data;
                                 state  <= ST_WAIT_OUT;
                             end
                ST_WAIT_OUT: if (out_ready) state <= ST_WRITE;
                ST_WRITE:    state <= ST_COMMIT;
                ST_COMMIT:   state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        strb = STROBES_IDLE;
        case (state)
            ST_READ:   begin
                           strb.oe_n = 1'b0;
                           strb.rd_n = (ph != PHW'(1));
                       end
            ST_WRITE:  begin
                           strb.wr_n  = 1'b0;
                           strb.drive = 1'b1;
                       end
            ST_COMMIT: strb.pkt_n = 1'b0;
            default:   ;
        endcase
    end
endmodule

// File: rtl/sfifo_reg_bridge.sv
module sfifo_reg_bridge
    import sfrb_pkg::*;
#(
    parameter bit           IN_RDY_LOW  = 1'b1,
    parameter bit           OUT_RDY_LOW = 1'b0,
    parameter int           RD_LAT      = 2,
    parameter int           DEPTH       = 16,
    parameter logic [31:0]  SEED        = 32'h1234_0000,
    parameter logic [31:0]  MISS        = 32'hDEAD_BEEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_flag,
    input  logic        out_flag,
    input  logic [31:0] dq_in,
    output logic [31:0] dq_out,
    output logic        dq_oe,
    output logic        oe_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic        pkt_end_n
);
    logic          in_ready;
    logic          out_ready;
    logic [31:0]   addr_q;
    logic [31:0]   lookup_data;
    logic [31:0]   data_q;
    sfrb_strobes_t strb;

    sfrb_flag_norm #(.ACT_LOW(IN_RDY_LOW)) u_in_flag (
        .flag_raw (in_flag),
        .ready    (in_ready)
    );

    sfrb_flag_norm #(.ACT_LOW(OUT_RDY_LOW)) u_out_flag (
        .flag_raw (out_flag),
        .ready    (out_ready)
    );

    sfrb_regfile #(
        .DW    (BUS_W),
        .DEPTH (DEPTH),
        .SEED  (SEED),
        .MISS  (MISS)
    ) u_regs (
        .addr  (addr_q),
        .rdata (lookup_data)
    );

    sfrb_ctrl #(
        .DW     (BUS_W),
        .RD_LAT (RD_LAT)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_ready    (in_ready),
        .out_ready   (out_ready),
        .dq_in       (dq_in),
        .lookup_data (lookup_data),
        .addr_q      (addr_q),
        .data_q      (data_q),
        .strb        (strb)
    );

    assign dq_out    = data_q;
    assign dq_oe     = strb.drive;
    assign oe_n      = strb.oe_n;
    assign rd_n      = strb.rd_n;
    assign wr_n      = strb.wr_n;
    assign pkt_end_n = strb.pkt_n;
endmodule

// File: rtl/sfrb_checker.sv
module sfrb_checker #(
    parameter bit IN_RDY_LOW  = 1'b1,
    parameter bit OUT_RDY_LOW = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic in_flag,
    input logic out_flag,
    input logic dq_oe,
    input logic oe_n,
    input logic rd_n,
    input logic wr_n,
    input logic pkt_end_n
);
    logic in_rdy;
    logic out_rdy;
    assign in_rdy  = IN_RDY_LOW  ? ~in_flag  : in_flag;
    assign out_rdy = OUT_RDY_LOW ? ~out_flag : out_flag;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (oe_n && rd_n && wr_n && pkt_end_n && !dq_oe));

    p_oe_needs_data_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> $past(in_rdy));

    p_oe_leads_rd_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!oe_n && $past(!oe_n)));

    p_rd_single_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_n |=> rd_n);

    p_wr_needs_space_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> $past(out_rdy));

    p_wr_single_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> wr_n);

    p_drive_only_in_write_r9: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!wr_n && oe_n));

    p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({~rd_n, ~wr_n, ~pkt_end_n}) <= 1);

    p_commit_after_write_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> !pkt_end_n);

    p_commit_single_r10: assert property (@(posedge clk) disable iff (rst)
        !pkt_end_n |=> pkt_end_n);
endmodule

bind sfifo_reg_bridge sfrb_checker #(
    .IN_RDY_LOW  (IN_RDY_LOW),
    .OUT_RDY_LOW (OUT_RDY_LOW)
) u_sfrb_chk (
    .clk       (clk),
    .rst       (rst),
    .in_flag   (in_flag),
    .out_flag  (out_flag),
    .dq_oe     (dq_oe),
    .oe_n      (oe_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .pkt_end_n (pkt_end_n)
);

// File: tb/tb_sfifo_reg_bridge.sv
`timescale 1ns/1ps
module tb_sfifo_reg_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_flag = 1'b1;
    logic        out_flag = 1'b1;
    logic [31:0] dq_in = 32'h0;
    logic [31:0] dq_out;
    logic        dq_oe, oe_n, rd_n, wr_n, pkt_end_n;

    always #10 clk = ~clk;

    sfifo_reg_bridge dut (
        .clk(clk), .rst(rst), .in_flag(in_flag), .out_flag(out_flag),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .oe_n(oe_n),
        .rd_n(rd_n), .wr_n(wr_n), .pkt_end_n(pkt_end_n)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int writes = 0;
    bit finished = 0;

    logic [31:0] host_q[$];
    logic [31:0] exp_q[$];
    bit          hold_in = 0;
    bit          out_space = 1;
    int          lat_cnt = 0;
    int          mst = 0;

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        if (a < 32'd64) return 32'h1234_0000 ^ ((a >> 2) * 32'h0101_0101);
        return 32'hDEAD_BEEF;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Behavioural reference: 0 idle, 1 wait data, 2..5 read window, 6 decode, 7 wait space, 8 write, 9 commit
    always @(posedge clk) begin
        cyc++;
        if (rst) mst = 0;
        else begin
            case (mst)
                0: mst = 1;
                1: if (in_flag == 1'b0) mst = 2;
                7: if (out_flag == 1'b1) mst = 8;
                9: mst = 0;
                default: mst = mst + 1;
            endcase
        end
    end

    always @(negedge clk) begin
        logic [31:0] e;
        string tag;
        // compare outputs with the model
        if (rst) begin
            chk(oe_n && rd_n && wr_n && pkt_end_n && !dq_oe, "R1",
                {27'd0, oe_n, rd_n, wr_n, pkt_end_n, dq_oe}, 32'h1E);
        end else begin
            chk(oe_n == !(mst >= 2 && mst <= 5), "R3", 32'(oe_n), 32'(!(mst >= 2 && mst <= 5)));
            chk(rd_n == !(mst == 3), "R4", 32'(rd_n), 32'(!(mst == 3)));
            chk(wr_n == !(mst == 8), "R8", 32'(wr_n), 32'(!(mst == 8)));
            chk(dq_oe == (mst == 8), "R9", 32'(dq_oe), 32'(mst == 8));
            chk(pkt_end_n == !(mst == 9), "R10", 32'(pkt_end_n), 32'(!(mst == 9)));
            if (mst == 8) begin
                writes++;
                if (exp_q.size() == 0) chk(0, "R10", 32'(writes), 32'(writes - 1));
                else begin
                    logic [31:0] a;
                    a = exp_q.pop_front();
                    e = exp_word(a);
                    tag = (a < 32'd64) ? "R6 (R5 capture)" : "R7 (R5 capture)";
                    chk(dq_out == e, tag, dq_out, e);
                end
            end
        end
        // bridge model: word appears on the bus two clocks after the strobe
        if (!rst && rd_n == 1'b0) begin
            lat_cnt = 2;
            if (host_q.size() > 0) exp_q.push_back(host_q[0]);
            dq_in = 32'hBAD0_0000 + 32'(cyc);
        end else if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                dq_in = (host_q.size() > 0) ? host_q.pop_front() : 32'hFFFF_0000;
            end else dq_in = 32'hBAD0_0000 + 32'(cyc);
        end else dq_in = 32'hBAD0_0000 + 32'(cyc);
        in_flag  = (host_q.size() > 0 && !hold_in && lat_cnt == 0) ? 1'b0 : 1'b1;
        out_flag = out_space ? 1'b1 : 1'b0;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R2: empty inbound channel, no read activity
        repeat (8) @(negedge clk);
        chk(oe_n == 1'b1, "R2", 32'(oe_n), 32'd1);
        host_q.push_back(32'h0000_0000);
        while (writes < 1) @(negedge clk);
        // R8: outbound full for a while
        out_space = 0;
        host_q.push_back(32'h0000_0004);
        repeat (30) @(negedge clk);
        chk(wr_n == 1'b1, "R8", 32'(wr_n), 32'd1);
        out_space = 1;
        while (writes < 2) @(negedge clk);
        // R2: data held back by the flag
        hold_in = 1;
        host_q.push_back(32'h0000_003C);
        repeat (12) @(negedge clk);
        chk(oe_n == 1'b1, "R2", 32'(oe_n), 32'd1);
        hold_in = 0;
        host_q.push_back(32'h0000_003F);
        host_q.push_back(32'h0000_0040);
        host_q.push_back(32'hFFFF_FFFC);
        host_q.push_back(32'h8000_0000);
        host_q.push_back(32'h0000_0026);
        while (writes < 8) @(negedge clk);
        repeat (15) @(negedge clk);
        chk(writes == 8, "R10", 32'(writes), 32'd8);
        chk(host_q.size() == 0 && exp_q.size() == 0, "R4",
            32'(host_q.size() + exp_q.size()), 32'd0);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 32'(cyc), 32'd0);
            summary();
        end
    end
endmodule